// File: doc/BRIEF.md
# Endian-Aware Load/Store Byte-Lane Aligner

This block sits between a 64-bit processor datapath and one naturally aligned memory element of eight bytes. For a load it takes the bytes fetched from memory, right-justified, trims them to the access length and moves them into the byte lanes the access occupies. The lane placement follows the selected endianness. For a store it does the reverse. It moves the register image down so that the referenced bytes sit at the low end for the memory write, trims the rest, and produces a byte-enable run that marks the lanes being written.

The address offset can first be folded by a reverse-endian XOR. Accesses that would spill past the element raise a boundary error. On that error all data and enables are forced to zero. A 16-byte access is carried as two untouched 64-bit halves. Word and halfword instruction fetches are checked for misalignment. The fetched value is extracted at an endian-adjusted byte select. The path is combinational, with an optional output register, and every flag appears in the same cycle as its data.

Top module: `lane_aligner`

## Requirements
- R1: With REG_OUT=1, while rst_n is low every output is zero.
- R2: The effective offset p equals addr_off when rev_end=0. When rev_end=1 it equals addr_off XOR (7 XOR len_code[2:0]). It is driven on phys_off.
- R3: len_code is the byte count minus one, so codes 0..7 mean 1..8 bytes and code 15 means a 16-byte access. bnd_err is 1 when p+len_code>7 for codes 0..14, and when p!=0 for code 15. Otherwise it is 0.
- R4: Little-endian load (big_end=0, no error, code 0..7): ld_lo equals rd_lo masked to its low len_code+1 bytes, shifted left by 8*p bits, and ld_hi is 0.
- R5: Big-endian load (big_end=1, no error, code 0..7): the masked rd_lo is shifted left by 8*(7-p-len_code) bits, so that offset 0 lands in the top lane.
- R6: Store (no error, code 0..7): st_lo equals wr_lo shifted right by the same bit count as the load, then masked to its low len_code+1 bytes. st_hi is 0.
- R7: byte_en holds len_code+1 consecutive ones whose lowest lane is the load shift in bytes (p for little-endian, 7-p-len_code for big-endian).
- R8: When bnd_err is 1, ld_lo, ld_hi, st_lo, st_hi and byte_en are all zero.
- R9: For code 15 with p=0, ld_lo/ld_hi equal rd_lo/rd_hi and st_lo/st_hi equal wr_lo/wr_hi, all unshifted, and byte_en is all ones.
- R10: fetch_exc is 1 exactly when is_fetch=1, len_code is 1 or 3, and (addr_off AND len_code) is nonzero.
- R11: fetch_val is the low 32 bits of ld_lo shifted right by 8*s bits. Here s = addr_off XOR (big_end ? 7 XOR len_code[2:0] : 0).
- R12: With REG_OUT=1 every output reflects the inputs of the previous rising clock edge. All flags and data come from the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| addr_off | input | 3 | Low address bits, offset inside the element |
| len_code | input | 4 | Access length code (bytes minus one, 15 = 16 bytes) |
| big_end | input | 1 | 1 selects big-endian lane order |
| rev_end | input | 1 | 1 applies the reverse-endian offset XOR |
| is_fetch | input | 1 | Access is an instruction fetch |
| rd_lo | input | 64 | Fetched memory data, low half (right-justified) |
| rd_hi | input | 64 | Fetched memory data, high half (16-byte access) |
| wr_lo | input | 64 | Register data to store, low half |
| wr_hi | input | 64 | Register data to store, high half |
| ld_lo | output | 64 | Lane-aligned load data, low half |
| ld_hi | output | 64 | Load data, high half |
| st_lo | output | 64 | Store data for memory, low half |
| st_hi | output | 64 | Store data, high half |
| byte_en | output | 8 | Byte enables of the referenced lanes |
| phys_off | output | 3 | Effective offset after the reverse-endian XOR |
| fetch_val | output | 32 | Value extracted for instruction fetch |
| bnd_err | output | 1 | Access crosses the element boundary |
| fetch_exc | output | 1 | Misaligned instruction fetch |

## Verification
The bench builds the block with ELEM_BYTES=8, FETCH_W=32 and REG_OUT=1. The registered variant therefore gets exercised, including its reset value and its one-edge latency, and the combinational lane logic is reached through that register. With eight-byte elements, every offset and every length code, the odd 3, 5, 6 and 7-byte sizes included, fits in a four-bit code. So random stimulus crosses every endianness and reverse-endian combination with both legal and boundary-crossing accesses. Directed vectors pin the top-lane big-endian byte, the full eight-byte access, the 16-byte pass-through and the fetch misalignment cases.

// File: rtl/aln_pkg.sv
package aln_pkg;
   typedef enum logic {
      LANE_LITTLE = 1'b0,
      LANE_BIG    = 1'b1
   } lane_order_e;

   // code reserved for the double-element access: bytes minus one
   function automatic int wide_code(input int eb);
      return 2 * eb - 1;
   endfunction
endpackage

// File: rtl/aln_decode.sv
module aln_decode #(
   parameter int EB    = 8,
   parameter int OFF_W = $clog2(EB),
   parameter int LEN_W = OFF_W + 1
) (
   input  logic [OFF_W-1:0] off,
   input  logic [LEN_W-1:0] len,
   input  aln_pkg::lane_order_e order,
   input  logic             rev,
   input  logic             fetch,
   output logic [OFF_W-1:0] p_eff,
   output logic             wide,
   output logic             err,
   output logic [OFF_W-1:0] shift_b,
   output logic [EB-1:0]    keep,
   output logic             fetch_exc,
   output logic [OFF_W-1:0] fetch_sel
);
   localparam logic [OFF_W-1:0] MASK  = OFF_W'(EB - 1);
   localparam logic [LEN_W-1:0] WCODE = LEN_W'(aln_pkg::wide_code(EB));
   localparam logic [LEN_W-1:0] HALF  = LEN_W'(1);
   localparam logic [LEN_W-1:0] WORD  = LEN_W'(3);

   logic [OFF_W-1:0] len_lo;
   logic [OFF_W-1:0] fold;
   logic [LEN_W:0]   reach;

   assign len_lo = len[OFF_W-1:0];
   assign fold   = MASK ^ len_lo;
   assign wide   = (len == WCODE);
   assign p_eff  = rev ? (off ^ fold) : off;
   assign reach  = {1'b0, p_eff} + {1'b0, len};

   always_comb begin
      if (wide) err = (p_eff != '0);
      else      err = (reach > (LEN_W+1)'(MASK));
   end

   always_comb begin
      if (wide)                             shift_b = '0;
      else if (order == aln_pkg::LANE_BIG)  shift_b = MASK - p_eff - len_lo;
      else                                  shift_b = p_eff;
   end

   for (genvar i = 0; i < EB; i++) begin : g_keep
      assign keep[i] = (len >= LEN_W'(i));
   end

   assign fetch_exc = fetch && ((len == HALF) || (len == WORD)) &&
                      ((off & len_lo) != '0);
   assign fetch_sel = (order == aln_pkg::LANE_BIG) ? (off ^ fold) : off;
endmodule

// File: rtl/aln_lane_shift.sv
module aln_lane_shift #(
   parameter int EB         = 8,
   parameter bit SHIFT_LEFT = 1'b1,
   parameter int OFF_W      = $clog2(EB),
   parameter int DW         = 8 * EB
) (
   input  logic [DW-1:0]    din,
   input  logic [OFF_W-1:0] lanes,
   output logic [DW-1:0]    dout
);
   logic [OFF_W+2:0] bits;
   assign bits = {lanes, 3'b000};

   if (SHIFT_LEFT) begin : g_left
      assign dout = din << bits;
   end else begin : g_right
      assign dout = din >> bits;
   end
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner #(
   parameter int ELEM_BYTES = 8,
   parameter int FETCH_W    = 32,
   parameter bit REG_OUT    = 1'b1,
   parameter int OFF_W      = $clog2(ELEM_BYTES),
   parameter int LEN_W      = OFF_W + 1,
   parameter int DW         = 8 * ELEM_BYTES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [OFF_W-1:0]   addr_off,
   input  logic [LEN_W-1:0]   len_code,
   input  logic               big_end,
   input  logic               rev_end,
   input  logic               is_fetch,
   input  logic [DW-1:0]      rd_lo,
   input  logic [DW-1:0]      rd_hi,
   input  logic [DW-1:0]      wr_lo,
   input  logic [DW-1:0]      wr_hi,
   output logic [DW-1:0]      ld_lo,
   output logic [DW-1:0]      ld_hi,
   output logic [DW-1:0]      st_lo,
   output logic [DW-1:0]      st_hi,
   output logic [ELEM_BYTES-1:0] byte_en,
   output logic [OFF_W-1:0]   phys_off,
   output logic [FETCH_W-1:0] fetch_val,
   output logic               bnd_err,
   output logic               fetch_exc
);
   localparam int EB    = ELEM_BYTES;
   localparam int BUS_W = 4 * DW + EB + OFF_W + FETCH_W + 2;

   if (EB < 2 || (EB & (EB - 1)) != 0) begin : g_bad_elem
      $error("ELEM_BYTES must be a power of two of at least 2");
   end
   if (FETCH_W < 8 || FETCH_W > DW) begin : g_bad_fetch
      $error("FETCH_W must lie between 8 and the element width");
   end

   aln_pkg::lane_order_e order;
   assign order = big_end ? aln_pkg::LANE_BIG : aln_pkg::LANE_LITTLE;

   logic [OFF_W-1:0] p_eff, shift_b, fetch_sel;
   logic             wide, err, exc;
   logic [EB-1:0]    keep;

   aln_decode #(.EB(EB)) u_dec (
      .off(addr_off), .len(len_code), .order(order), .rev(rev_end),
      .fetch(is_fetch), .p_eff(p_eff), .wide(wide), .err(err),
      .shift_b(shift_b), .keep(keep), .fetch_exc(exc), .fetch_sel(fetch_sel)
   );

   logic [DW-1:0] keep_bits;
   for (genvar i = 0; i < EB; i++) begin : g_expand
      assign keep_bits[8*i +: 8] = {8{keep[i]}};
   end

   logic [DW-1:0] ld_shift, st_shift, rd_trim;
   assign rd_trim = rd_lo & keep_bits;

   aln_lane_shift #(.EB(EB), .SHIFT_LEFT(1'b1)) u_ld_sh (
      .din(rd_trim), .lanes(shift_b), .dout(ld_shift)
   );
   aln_lane_shift #(.EB(EB), .SHIFT_LEFT(1'b0)) u_st_sh (
      .din(wr_lo), .lanes(shift_b), .dout(st_shift)
   );

   logic [DW-1:0] c_ld_lo, c_ld_hi, c_st_lo, c_st_hi;
   logic [EB-1:0] c_be;
   always_comb begin
      c_ld_lo = '0;
      c_ld_hi = '0;
      c_st_lo = '0;
      c_st_hi = '0;
      c_be    = '0;
      if (!err) begin
         if (wide) begin
            c_ld_lo = rd_lo;
            c_ld_hi = rd_hi;
            c_st_lo = wr_lo;
            c_st_hi = wr_hi;
            c_be    = '1;
         end else begin
            c_ld_lo = ld_shift;
            c_st_lo = st_shift & keep_bits;
            c_be    = keep << shift_b;
         end
      end
   end

   logic [DW-1:0] fetch_full;
   aln_lane_shift #(.EB(EB), .SHIFT_LEFT(1'b0)) u_fe_sh (
      .din(c_ld_lo), .lanes(fetch_sel), .dout(fetch_full)
   );

   logic [BUS_W-1:0] c_bus, q_bus;
   assign c_bus = {c_ld_lo, c_ld_hi, c_st_lo, c_st_hi, c_be, p_eff,
                   fetch_full[FETCH_W-1:0], err, exc};

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_bus <= '0;
         else        q_bus <= c_bus;
      end
   end else begin : g_comb
      assign q_bus = c_bus;
   end

   assign {ld_lo, ld_hi, st_lo, st_hi, byte_en, phys_off,
           fetch_val, bnd_err, fetch_exc} = q_bus;
endmodule

// File: rtl/lane_aligner_chk.sv
module lane_aligner_chk #(
   parameter int ELEM_BYTES = 8,
   parameter bit REG_OUT    = 1'b1,
   parameter int OFF_W      = $clog2(ELEM_BYTES),
   parameter int LEN_W      = OFF_W + 1,
   parameter int DW         = 8 * ELEM_BYTES
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [OFF_W-1:0]      addr_off,
   input logic [LEN_W-1:0]      len_code,
   input logic                  rev_end,
   input logic                  is_fetch,
   input logic [DW-1:0]         rd_hi,
   input logic [DW-1:0]         ld_lo,
   input logic [DW-1:0]         ld_hi,
   input logic [DW-1:0]         st_lo,
   input logic [ELEM_BYTES-1:0] byte_en,
   input logic [OFF_W-1:0]      phys_off,
   input logic                  bnd_err,
   input logic                  fetch_exc
);
   localparam logic [LEN_W-1:0] WCODE = LEN_W'(2 * ELEM_BYTES - 1);

   logic [OFF_W-1:0] off_q;
   logic [LEN_W-1:0] len_q;
   logic             rev_q, fetch_q, armed;
   logic [DW-1:0]    rdh_q;

   if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            off_q <= '0; len_q <= '0; rev_q <= 1'b0; fetch_q <= 1'b0;
            rdh_q <= '0; armed <= 1'b0;
         end else begin
            off_q <= addr_off; len_q <= len_code; rev_q <= rev_end;
            fetch_q <= is_fetch; rdh_q <= rd_hi; armed <= 1'b1;
         end
      end
   end else begin : g_now
      assign off_q = addr_off;
      assign len_q = len_code;
      assign rev_q = rev_end;
      assign fetch_q = is_fetch;
      assign rdh_q = rd_hi;
      assign armed = 1'b1;
   end

   // R8
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && bnd_err) |-> (byte_en == '0 && ld_lo == '0 && st_lo == '0));
   // R7
   be_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !bnd_err && len_q != WCODE) |->
      ($countones(byte_en) == int'(len_q) + 1));
   // R10
   exc_fetch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && fetch_exc) |-> fetch_q);
   // R9
   wide_hi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !bnd_err && len_q == WCODE) |-> (ld_hi == rdh_q && byte_en == '1));
   // R2
   no_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !rev_q) |-> (phys_off == off_q));
endmodule

bind lane_aligner lane_aligner_chk #(
   .ELEM_BYTES(ELEM_BYTES), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr_off(addr_off), .len_code(len_code),
   .rev_end(rev_end), .is_fetch(is_fetch), .rd_hi(rd_hi), .ld_lo(ld_lo),
   .ld_hi(ld_hi), .st_lo(st_lo), .byte_en(byte_en), .phys_off(phys_off),
   .bnd_err(bnd_err), .fetch_exc(fetch_exc)
);

// File: tb/sim_lane_aligner.sv
module sim_lane_aligner;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  addr_off = '0;
   logic [3:0]  len_code = '0;
   logic        big_end = 1'b0, rev_end = 1'b0, is_fetch = 1'b0;
   logic [63:0] rd_lo = '0, rd_hi = '0, wr_lo = '0, wr_hi = '0;
   logic [63:0] ld_lo, ld_hi, st_lo, st_hi;
   logic [7:0]  byte_en;
   logic [2:0]  phys_off;
   logic [31:0] fetch_val;
   logic        bnd_err, fetch_exc;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_aligner #(.ELEM_BYTES(8), .FETCH_W(32), .REG_OUT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .addr_off(addr_off), .len_code(len_code),
      .big_end(big_end), .rev_end(rev_end), .is_fetch(is_fetch),
      .rd_lo(rd_lo), .rd_hi(rd_hi), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .ld_lo(ld_lo), .ld_hi(ld_hi), .st_lo(st_lo), .st_hi(st_hi),
      .byte_en(byte_en), .phys_off(phys_off), .fetch_val(fetch_val),
      .bnd_err(bnd_err), .fetch_exc(fetch_exc)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] trim(input int len);
      if (len >= 7) return '1;
      return (64'd1 << (8 * (len + 1))) - 64'd1;
   endfunction

   // Drive one vector at a falling edge, check one edge later (R12)
   task automatic run(input logic [2:0] off, input logic [3:0] len,
                      input logic be, input logic rv, input logic fe);
      int p, sh, s;
      bit wide, err, exc;
      logic [63:0] m, e_ld, e_ldh, e_st, e_sth;
      logic [7:0]  e_be;
      logic [31:0] e_fv;
      @(negedge clk);
      addr_off = off; len_code = len; big_end = be; rev_end = rv; is_fetch = fe;
      rd_lo = {$urandom, $urandom}; rd_hi = {$urandom, $urandom};
      wr_lo = {$urandom, $urandom}; wr_hi = {$urandom, $urandom};
      p    = rv ? int'(off ^ (3'd7 ^ len[2:0])) : int'(off);
      wide = (len == 4'd15);
      err  = wide ? (p != 0) : (p + int'(len) > 7);
      sh   = wide ? 0 : (be ? 7 - p - int'(len) : p);
      m    = trim(int'(len));
      e_ld = '0; e_ldh = '0; e_st = '0; e_sth = '0; e_be = '0;
      if (!err && wide) begin
         e_ld = rd_lo; e_ldh = rd_hi; e_st = wr_lo; e_sth = wr_hi; e_be = '1;
      end else if (!err) begin
         e_ld = (rd_lo & m) << (8 * sh);
         e_st = (wr_lo >> (8 * sh)) & m;
         e_be = 8'(((16'd1 << (int'(len) + 1)) - 16'd1) << sh);
      end
      exc  = fe && (len == 4'd1 || len == 4'd3) && ((off & len[2:0]) != 3'd0);
      s    = int'(be ? (off ^ (3'd7 ^ len[2:0])) : off);
      e_fv = 32'(e_ld >> (8 * s));
      @(negedge clk);
      chk("R2", "phys_off", 64'(phys_off), 64'(p));
      chk("R3", "bnd_err", 64'(bnd_err), 64'(err));
      chk(err ? "R8" : (wide ? "R9" : (be ? "R5" : "R4")), "ld_lo", ld_lo, e_ld);
      chk(err ? "R8" : (wide ? "R9" : "R4"), "ld_hi", ld_hi, e_ldh);
      chk(err ? "R8" : (wide ? "R9" : "R6"), "st_lo", st_lo, e_st);
      chk(err ? "R8" : (wide ? "R9" : "R6"), "st_hi", st_hi, e_sth);
      chk(err ? "R8" : "R7", "byte_en", 64'(byte_en), 64'(e_be));
      chk("R10", "fetch_exc", 64'(fetch_exc), 64'(exc));
      chk("R11", "fetch_val", 64'(fetch_val), 64'(e_fv));
   endtask

   initial begin
      int seed;
      seed = 32'h5a17;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // R1: registered outputs are cleared while reset is held
      chk("R1", "ld_lo", ld_lo, '0);
      chk("R1", "st_lo", st_lo, '0);
      chk("R1", "flags", {62'd0, bnd_err, fetch_exc}, '0);
      chk("R1", "byte_en", 64'(byte_en), '0);
      rst_n = 1'b1;
      // directed corners
      run(3'd4, 4'd3, 1'b0, 1'b0, 1'b0);  // R4 LE word in upper half
      run(3'd0, 4'd3, 1'b1, 1'b0, 1'b0);  // R5 BE word at offset 0
      run(3'd7, 4'd0, 1'b1, 1'b0, 1'b0);  // R5 BE last byte -> lane 0
      run(3'd0, 4'd7, 1'b0, 1'b0, 1'b0);  // R7 full element
      run(3'd1, 4'd6, 1'b1, 1'b0, 1'b0);  // R6 seven bytes
      run(3'd2, 4'd4, 1'b0, 1'b0, 1'b0);  // R6 five bytes
      run(3'd5, 4'd3, 1'b0, 1'b0, 1'b0);  // R3 R8 crossing
      run(3'd0, 4'd9, 1'b0, 1'b0, 1'b0);  // R3 illegal code
      run(3'd0, 4'd15, 1'b1, 1'b0, 1'b0); // R9 16-byte pass
      run(3'd1, 4'd15, 1'b0, 1'b0, 1'b0); // R3 16-byte misaligned
      run(3'd0, 4'd0, 1'b0, 1'b1, 1'b0);  // R2 fold byte offset 0 -> 7
      run(3'd4, 4'd3, 1'b1, 1'b1, 1'b0);  // R2 fold word
      run(3'd2, 4'd1, 1'b0, 1'b0, 1'b1);  // R10 aligned half fetch
      run(3'd1, 4'd1, 1'b1, 1'b0, 1'b1);  // R10 misaligned half
      run(3'd2, 4'd3, 1'b0, 1'b0, 1'b1);  // R10 misaligned word
      run(3'd2, 4'd3, 1'b0, 1'b0, 1'b0);  // R10 not a fetch
      run(3'd4, 4'd3, 1'b1, 1'b0, 1'b1);  // R11 BE word fetch
      for (int i = 0; i < 600; i++) begin
         logic [3:0] ln;
         ln = ($urandom % 5 == 0) ? 4'($urandom) : 4'($urandom % 8);
         run(3'($urandom), ln, 1'($urandom), 1'($urandom), 1'($urandom));
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R12 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule